// File: doc/BRIEF.md
# Synthesizer Loop Divider and Phase Comparator

This block is the digital heart of a tuner frequency synthesizer. A 15-bit down-counter divides the prescaled oscillator pulses by a programmed ratio N. A second counter divides the reference clock by 256, 512 or 1024, or is switched off. A two-flop phase-frequency detector compares the two divided pulse trains and issues pump-up and pump-down requests for an external charge pump. When settled, the oscillator runs at 8 × N × f_ref / R.

The design runs on one system clock. Both the prescaled oscillator and the reference arrive as one-cycle tick enables. Control inputs can silence the pump, send the two divided pulse trains to test pins, drop the varicap drive and pick the pump current level. A lock flag reports when the phase error has stayed small for several comparisons in a row.

Top module: `pll_divider_core`

## Requirements
- R1: While `rst_n` is low, `pump_up`, `pump_dn`, `locked`, `tst_vco` and `tst_ref` are all low.
- R2: The programmable divider emits one divided pulse for every N counted `vco_tick`s, where N = `n_word` (15 bits, usable 2..32767; the intended tuning range is 256..32767). With ticks on every other clock the pulse period is 2N clocks.
- R3: A new `n_word` is loaded only when the running count reaches its terminal count. The interval in progress keeps its old length and the following interval uses the new ratio.
- R4: `ref_sel` chooses the reference ratio: 2'b01 gives 1024, 2'b10 gives 256 and 2'b11 gives 512. With 2'b00 the reference divider stops: there are no reference pulses, `pump_up` and `pump_dn` stay low and `locked` is low.
- R5: When the divided reference pulse arrives before the divided oscillator pulse, `pump_up` is high from the cycle after the reference pulse until the detector clears, and `pump_dn` stays low. The mirror case drives `pump_dn`. Both are high together for at most one cycle.
- R6: `cp_off` = 1 holds `pump_up` and `pump_dn` low while the detector keeps running.
- R7: With `tst_en` = 1, the divided oscillator and reference pulses appear on `tst_vco` and `tst_ref`. With `tst_en` = 0 both pins stay low.
- R8: `drv_en` is the inverse of `drv_off`, and `cp_hi` follows `cp_hi_sel` (1 = high pump current).
- R9: `locked` rises after LOCK_CYC consecutive comparisons (default 4) whose one-sided pulse width is at most LOCK_WIN clocks (default 6). It falls as soon as a one-sided width exceeds LOCK_WIN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vco_tick | input | 1 | One-cycle enable per prescaled oscillator period |
| ref_tick | input | 1 | One-cycle enable per reference oscillator period |
| n_word | input | 15 | Programmable divider ratio N |
| ref_sel | input | 2 | Reference ratio select (00 off, 01 /1024, 10 /256, 11 /512) |
| cp_off | input | 1 | Silence pump requests |
| tst_en | input | 1 | Route divided pulses to the test pins |
| drv_off | input | 1 | Drop the varicap drive |
| cp_hi_sel | input | 1 | Pump current level select |
| pump_up | output | 1 | Pump-up request |
| pump_dn | output | 1 | Pump-down request |
| cp_hi | output | 1 | Pump current level to the analog pump |
| drv_en | output | 1 | Varicap drive enable |
| tst_vco | output | 1 | Divided oscillator pulse for test |
| tst_ref | output | 1 | Divided reference pulse for test |
| locked | output | 1 | Lock indication |

## Verification
A divided pulse appears on the test pins one clock after the tick that reaches the terminal count, and pump requests follow one clock after that. The bench therefore samples on falling edges and measures divider periods as the distance between two test-pin pulses, discarding the first interval after any reconfiguration because of the terminal-count load rule. Pump polarity is checked on the first and second falling edges after a reference pulse is seen. The lock flag needs several comparison periods to settle, so it is sampled only after windows that span a known number of comparisons.

// File: rtl/pll_divider_core.sv
module pll_divider_core #(
  parameter int NW       = 15,
  parameter int LOCK_CYC = 4,
  parameter int LOCK_WIN = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vco_tick,
  input  logic          ref_tick,
  input  logic [NW-1:0] n_word,
  input  logic [1:0]    ref_sel,
  input  logic          cp_off,
  input  logic          tst_en,
  input  logic          drv_off,
  input  logic          cp_hi_sel,
  output logic          pump_up,
  output logic          pump_dn,
  output logic          cp_hi,
  output logic          drv_en,
  output logic          tst_vco,
  output logic          tst_ref,
  output logic          locked
);
  localparam int RW = 11;
  localparam int WW = $clog2(LOCK_WIN + 2);
  localparam int GW = $clog2(LOCK_CYC + 1);

  logic [NW-1:0] vcnt;
  logic [RW-1:0] rcnt, rload;
  logic          vdiv, rdiv, up_ff, dn_ff, lock_q;
  logic [WW-1:0] wcnt;
  logic [GW-1:0] good;

  wire ref_on = |ref_sel;
  wire both   = up_ff & dn_ff;
  wire act    = ref_on & ~cp_off;
  wire bad    = wcnt > WW'(LOCK_WIN);

  always_comb
    case (ref_sel)
      2'b01:   rload = RW'(1024);
      2'b10:   rload = RW'(256);
      default: rload = RW'(512);
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      vcnt <= '0;
      vdiv <= 1'b0;
    end else begin
      vdiv <= vco_tick && (vcnt <= NW'(1));
      if (vco_tick) vcnt <= (vcnt <= NW'(1)) ? n_word : vcnt - NW'(1);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rcnt <= '0;
      rdiv <= 1'b0;
    end else if (!ref_on) begin
      rcnt <= '0;
      rdiv <= 1'b0;
    end else begin
      rdiv <= ref_tick && (rcnt <= RW'(1));
      if (ref_tick) rcnt <= (rcnt <= RW'(1)) ? rload : rcnt - RW'(1);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      up_ff <= 1'b0;
      dn_ff <= 1'b0;
      wcnt  <= '0;
    end else if (!ref_on || both) begin
      up_ff <= 1'b0;
      dn_ff <= 1'b0;
      wcnt  <= '0;
    end else begin
      up_ff <= up_ff | rdiv;
      dn_ff <= dn_ff | vdiv;
      if ((up_ff ^ dn_ff) && !bad) wcnt <= wcnt + WW'(1);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      good   <= '0;
      lock_q <= 1'b0;
    end else if (!ref_on || bad) begin
      good   <= '0;
      lock_q <= 1'b0;
    end else if (both) begin
      if (good < GW'(LOCK_CYC)) good <= good + GW'(1);
      if (good >= GW'(LOCK_CYC - 1)) lock_q <= 1'b1;
    end

  assign pump_up = up_ff & act;
  assign pump_dn = dn_ff & act;
  assign cp_hi   = cp_hi_sel;
  assign drv_en  = ~drv_off;
  assign tst_vco = tst_en & vdiv;
  assign tst_ref = tst_en & rdiv;
  assign locked  = lock_q;

  a_r2_pulse_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    vdiv |-> $past(vco_tick));
  a_r3_load_at_terminal: assert property (@(posedge clk) disable iff (!rst_n)
    vdiv |-> vcnt == $past(n_word));
  a_r4_off_no_ref: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_on |=> !rdiv);
  a_r5_overlap_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    both |=> !up_ff && !dn_ff);
  a_r9_drop_on_wide: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> !lock_q);
  a_r9_rise_on_compare: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> $past(both));
endmodule

// File: tb/sim_pll_divider_core.sv
`timescale 1ns/1ps
module sim_pll_divider_core;
  logic clk = 1'b0, rst_n = 1'b0;
  logic vco_tick = 1'b1, ref_tick = 1'b1, half = 1'b0;
  logic [14:0] n_word = 15'd256;
  logic [1:0] ref_sel = 2'b10;
  logic cp_off = 1'b0, tst_en = 1'b1, drv_off = 1'b0, cp_hi_sel = 1'b0;
  logic pump_up, pump_dn, cp_hi, drv_en, tst_vco, tst_ref, locked;
  int nvec = 0, nbad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;
  always @(negedge clk) vco_tick <= half ? ~vco_tick : 1'b1;

  pll_divider_core u0 (.clk(clk), .rst_n(rst_n), .vco_tick(vco_tick), .ref_tick(ref_tick),
    .n_word(n_word), .ref_sel(ref_sel), .cp_off(cp_off), .tst_en(tst_en), .drv_off(drv_off),
    .cp_hi_sel(cp_hi_sel), .pump_up(pump_up), .pump_dn(pump_dn), .cp_hi(cp_hi), .drv_en(drv_en),
    .tst_vco(tst_vco), .tst_ref(tst_ref), .locked(locked));

  // n, ref_sel, half-rate ticks, expected divided-VCO period, expected reference period
  localparam int VEC[6][5] = '{
    '{256,   2, 0, 256,   256},
    '{300,   1, 0, 300,  1024},
    '{1000,  3, 0, 1000,  512},
    '{2,     3, 0, 2,     512},
    '{400,   2, 1, 800,   256},
    '{32767, 2, 0, 32767, 256}};

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic meas(input bit rside, output int per);
    int c = 0;
    per = -1;
    while (!(rside ? tst_ref : tst_vco) && c < 40000) begin @(negedge clk); c++; end
    @(negedge clk);
    c = 1;
    while (!(rside ? tst_ref : tst_vco) && c < 40000) begin @(negedge clk); c++; end
    if (c < 40000) per = c;
  endtask

  task automatic window(input int n, output int ups, output int dns, output int ones, output int tv, output int tr);
    ups = 0; dns = 0; ones = 0; tv = 0; tr = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ups += int'(pump_up); dns += int'(pump_dn);
      ones += int'(pump_up ^ pump_dn);
      tv += int'(tst_vco); tr += int'(tst_ref);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    int p, u, d, o, tv, tr, c;
    repeat (2) @(negedge clk);
    chk("R1 up in reset", int'(pump_up), 0);
    chk("R1 dn in reset", int'(pump_dn), 0);
    chk("R1 lock in reset", int'(locked), 0);
    chk("R1 test pins in reset", int'(tst_vco | tst_ref), 0);
    rst_n = 1'b1;

    foreach (VEC[i]) begin
      n_word = 15'(VEC[i][0]); ref_sel = 2'(VEC[i][1]); half = VEC[i][2][0];
      meas(1'b0, p); meas(1'b0, p);
      chk("R2 divided VCO period", p, VEC[i][3]);
      meas(1'b1, p); meas(1'b1, p);
      chk("R4 reference period", p, VEC[i][4]);
    end
    half = 1'b0;

    // R3: change ratio mid-interval
    n_word = 15'd300;
    meas(1'b0, p); meas(1'b0, p);
    while (!tst_vco) @(negedge clk);
    c = 0;
    do begin
      @(negedge clk); c++;
      if (c == 10) n_word = 15'd256;
    end while (!tst_vco && c < 1000);
    chk("R3 interval in progress keeps old ratio", c, 300);
    meas(1'b0, p);
    chk("R3 next interval uses new ratio", p, 256);

    // R5 reference leads
    n_word = 15'd260; ref_sel = 2'b10; do_reset();
    repeat (100) @(negedge clk);
    while (!tst_ref) @(negedge clk);
    @(negedge clk); chk("R5 up after ref lead", int'(pump_up), 1); chk("R5 dn quiet", int'(pump_dn), 0);
    @(negedge clk); chk("R5 up held", int'(pump_up), 1);
    // R5 VCO leads
    n_word = 15'd252; do_reset();
    repeat (100) @(negedge clk);
    while (!tst_vco) @(negedge clk);
    @(negedge clk); chk("R5 dn after VCO lead", int'(pump_dn), 1); chk("R5 up quiet", int'(pump_up), 0);

    // R6 pump silenced
    n_word = 15'd260; cp_off = 1'b1; do_reset();
    window(700, u, d, o, tv, tr);
    chk("R6 up silenced", u, 0);
    chk("R6 dn silenced", d, 0);
    chk("R6 detector still compares", int'(tv > 0 && tr > 0), 1);
    cp_off = 1'b0;

    // R7 test routing off
    tst_en = 1'b0;
    window(700, u, d, o, tv, tr);
    chk("R7 test pins quiet", tv + tr, 0);
    tst_en = 1'b1;

    // R8 mirrors
    drv_off = 1'b1; cp_hi_sel = 1'b1; @(negedge clk);
    chk("R8 drive dropped", int'(drv_en), 0); chk("R8 high current", int'(cp_hi), 1);
    drv_off = 1'b0; cp_hi_sel = 1'b0; @(negedge clk);
    chk("R8 drive on", int'(drv_en), 1); chk("R8 low current", int'(cp_hi), 0);

    // R9 lock and R5 overlap
    n_word = 15'd256; ref_sel = 2'b10; do_reset();
    window(600, u, d, o, tv, tr);
    chk("R9 not yet locked after three compares", int'(locked), 0);
    window(900, u, d, o, tv, tr);
    chk("R5 no one-sided pulse when aligned", o, 0);
    chk("R5 overlap one cycle per compare", int'(u == d && u >= 3 && u <= 6), 1);
    chk("R9 locked", int'(locked), 1);
    n_word = 15'd264;
    window(600, u, d, o, tv, tr);
    chk("R9 lock lost on wide error", int'(locked), 0);

    // R4 reference off
    ref_sel = 2'b00;
    window(2100, u, d, o, tv, tr);
    chk("R4 no reference pulses when off", tr, 0);
    chk("R4 pump quiet when off", u + d, 0);
    chk("R4 unlocked when off", int'(locked), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule